// File: doc/BRIEF.md
# Double-Buffered SPI Controller

This block is a memory-mapped serial peripheral that acts either as the clock-generating master or as a clocked slave. A single shift register moves data both ways at once. A transmit holding register sits on one side of it and a receive holding register on the other. Software queues the next word and collects the last one through one data address. A write to that address fills the transmit side, and a read from it drains the receive side.

Frames are 8 or 16 bits, sent most significant bit first. The clock idles low, the outgoing bit changes on the falling edge and the incoming bit is taken on the rising edge. When a frame ends, the received word goes to the receive register and the interrupt flag is raised. A queued transmit word drops into the shift register in the same cycle. A master keeps clocking without releasing select as long as words stay queued. If a frame ends while the previous word has not been read, the new word is thrown away and an overflow bit freezes the shifter until software reads the data register.

Register map (bus_addr): 0 = data, 1 = control, 2 = status. Control bits: [0] enable, [1] master, [2] 16-bit frame, [3] interrupt enable, [15:8] half-period of the master clock in system clocks (0 counts as 1). Status bits: [0] receive full, [1] transmit full, [2] overflow, [3] interrupt flag (writing 1 clears it), [4] master frame in progress.

Top module: `spi_dbuf`

## Requirements
- R1: After reset the status and control registers read 0, ss_n_o is 1, sck_o is 0, sck_oe is 0 and irq is 0.
- R2: In master mode with 8-bit frames, a queued word is sent MSB first on sdo, with 8 rising edges on sck_o spaced 2*half-period system clocks apart. The 8 bits sampled from sdi on those rising edges are placed in bits [7:0] of the data register, and bits [15:8] read 0.
- R3: With the 16-bit frame bit set, a master frame moves 16 bits each way, MSB first.
- R4: The master holds ss_n_o low for the whole frame, and sck_o is low whenever ss_n_o is high.
- R5: Each completed frame sets status bit 3. Writing 1 to status bit 3 clears it. irq equals status bit 3 AND control bit 3.
- R6: Status bit 0 is set when a word enters the receive register and is cleared by a data read. Status bit 1 is set by a data write and cleared when the word moves into the shift register.
- R7: If a transmit word is queued when a master frame ends, it is loaded into the shift register at once and the next frame follows with ss_n_o still low.
- R8: If a frame ends while status bit 0 is still set, status bit 2 is set, the new word is lost, and the data register keeps the old word.
- R9: While status bit 2 is set, the slave ignores sck_i edges, so no frame completes. A data read clears bits 2 and 0 and shifting resumes.
- R10: In slave mode (control bit 1 = 0), sdo presents the loaded word MSB first, changing after sck_i falling edges, and sdi is taken on sck_i rising edges. While ss_n_i is high, sdo is 0 and the bit count returns to zero, so a partial frame is abandoned.
- R11: A write to the data address only fills the transmit side. A read of that address returns the receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (side effects on data address) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data (combinational) |
| irq | output | 1 | Interrupt request |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sck_i | input | 1 | Shift clock from an external master |
| sck_o | output | 1 | Shift clock driven in master mode |
| sck_oe | output | 1 | High when sck_o should drive the pin |
| ss_n_i | input | 1 | Active-low select from an external master |
| ss_n_o | output | 1 | Active-low select driven in master mode |

## Verification
The master path is driven with asymmetric bit patterns that differ in each direction (A5 against 3C, C3A1 against 5E96). These catch bit-order reversal, a wrong frame length and a swap of the transmit and receive sides. A two-word run with distinct halves (81/7E sent, 12/34 received) shows whether the queued word is loaded at completion without a gap in select. The slave path gets a normal frame, an overflowing frame and a frame sent during overflow. Each frame has its own pattern, so a lost word, an overwritten buffer and a frozen shifter are told apart. A three-pulse aborted frame followed by a full one shows whether deasserting select resets the bit count.

// File: rtl/spi_dbuf.sv
module spi_dbuf #(
  parameter int DIVW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  input  logic        sdi,
  output logic        sdo,
  input  logic        sck_i,
  output logic        sck_o,
  output logic        sck_oe,
  input  logic        ss_n_i,
  output logic        ss_n_o
);
  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

  logic [15:0]     sr, rxbuf, txbuf, word;
  logic [3:0]      ctl, bitcnt;
  logic [DIVW-1:0] hdiv, hcnt, hmax;
  logic            rxfull, txfull, ovf, irqf, busy, samp;
  logic [1:0]      sck_q, sdi_q, ss_q;
  logic            sck_d;

  wire en   = ctl[0];
  wire mst  = ctl[1];
  wire wide = ctl[2];
  wire ien  = ctl[3];

  assign hmax = (hdiv == '0) ? '0 : hdiv - 1'b1;
  wire tick   = busy & mst & (hcnt == hmax);
  wire s_act  = en & ~mst & ~ss_q[1] & ~ovf;
  wire s_rise = s_act & sck_q[1] & ~sck_d;
  wire s_fall = s_act & ~sck_q[1] & sck_d;
  wire rise   = mst ? (tick & ~sck_o) : s_rise;
  wire fall   = mst ? (tick & sck_o) : s_fall;
  wire last   = bitcnt == (wide ? 4'd15 : 4'd7);
  wire done   = fall & last;
  wire rd_data = bus_rd & (bus_addr == A_DATA);
  wire room    = ~rxfull | rd_data;
  wire m_start = en & mst & ~busy & txfull & ~ovf;
  wire s_load  = en & ~mst & ss_q[1] & txfull;
  wire tx_take = m_start | s_load | (done & txfull & (~mst | room));
  wire sdi_in  = mst ? sdi : sdi_q[1];

  assign word = wide ? {sr[14:0], samp} : {8'h00, sr[6:0], samp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; rxbuf <= '0; txbuf <= '0; ctl <= '0; hdiv <= '0; hcnt <= '0;
      bitcnt <= '0; rxfull <= 1'b0; txfull <= 1'b0; ovf <= 1'b0; irqf <= 1'b0;
      busy <= 1'b0; samp <= 1'b0; sck_o <= 1'b0;
      sck_q <= '0; sdi_q <= '0; ss_q <= 2'b11; sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[0], sck_i};
      sdi_q <= {sdi_q[0], sdi};
      ss_q  <= {ss_q[0], ss_n_i};
      sck_d <= sck_q[1];
      if (bus_wr && bus_addr == A_CTRL) begin
        ctl  <= bus_wdata[3:0];
        hdiv <= bus_wdata[8 +: DIVW];
      end
      if (rise) samp <= sdi_in;
      if (fall) begin
        sr     <= {sr[14:0], samp};
        bitcnt <= last ? 4'd0 : bitcnt + 4'd1;
      end
      if (~mst & ss_q[1]) bitcnt <= '0;
      if (busy & mst) begin
        hcnt <= tick ? '0 : hcnt + 1'b1;
        if (tick) sck_o <= ~sck_o;
      end
      if (bus_wr && bus_addr == A_STAT && bus_wdata[3]) irqf <= 1'b0;
      if (done) begin
        irqf <= 1'b1;
        if (room) rxbuf <= word;
        else      ovf <= 1'b1;
        if (mst & ~(txfull & room)) busy <= 1'b0;
      end
      if (m_start) begin
        busy <= 1'b1; hcnt <= '0; sck_o <= 1'b0; bitcnt <= '0;
      end
      if (!en || !mst) begin
        busy <= 1'b0; sck_o <= 1'b0;
      end
      if (tx_take) begin
        sr <= txbuf; txfull <= 1'b0;
      end
      if (rd_data) begin
        rxfull <= 1'b0; ovf <= 1'b0;
      end
      if (done & room) rxfull <= 1'b1;
      if (bus_wr && bus_addr == A_DATA) begin
        txbuf <= bus_wdata; txfull <= 1'b1;
      end
    end
  end

  wire drive = mst ? busy : (en & ~ss_q[1]);
  assign sdo    = drive & (wide ? sr[15] : sr[7]);
  assign ss_n_o = ~(busy & mst);
  assign sck_oe = en & mst;
  assign irq    = irqf & ien;

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rxbuf;
      A_CTRL:  bus_rdata = {hdiv, 4'h0, ctl};
      A_STAT:  bus_rdata = {11'd0, busy, irqf, ovf, txfull, rxfull};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        room,
  input logic        ovf,
  input logic        rxfull,
  input logic [15:0] rxbuf,
  input logic        irqf,
  input logic        mst,
  input logic        busy,
  input logic        sck_o,
  input logic        ss_n_o,
  input logic        ss_s,
  input logic [3:0]  bitcnt
);
  a_r2_clock_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> (mst && busy));
  a_r4_clock_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_o |-> !sck_o);
  a_r5_flag_from_completion: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqf) |-> $past(done));
  a_r6_rx_marked_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done && room) |=> rxfull);
  a_r8_old_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !room) |=> (ovf && $stable(rxbuf)));
  a_r9_frozen_shifter: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst && ovf && !ss_s) |=> $stable(bitcnt));
endmodule

bind spi_dbuf spi_dbuf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .room(room), .ovf(ovf),
  .rxfull(rxfull), .rxbuf(rxbuf), .irqf(irqf), .mst(ctl[1]), .busy(busy),
  .sck_o(sck_o), .ss_n_o(ss_n_o), .ss_s(ss_q[1]), .bitcnt(bitcnt)
);

// File: tb/spi_dbuf_tb_top.sv
module spi_dbuf_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq, sdi = 1'b0, sdo, sck_i = 1'b0, sck_o, sck_oe, ss_n_i = 1'b1, ss_n_o;
  int checks = 0, errs = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_dbuf dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sdi(sdi), .sdo(sdo), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .ss_n_i(ss_n_i), .ss_n_o(ss_n_o));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // bench acting as a slave for the master; optional read/write mid-run
  task automatic m_run(input int n, input logic [15:0] pat, input int wr_at,
                       input logic [15:0] wr_val, input int rd_at,
                       input logic [15:0] rd_exp, output logic [15:0] cap);
    time t0 = 0;
    logic [15:0] d;
    cap = '0;
    for (int i = 0; i < n; i++) begin
      @(posedge sck_o);
      cap = {cap[14:0], sdo};
      check("R4 select low at rising edge", {15'd0, ss_n_o}, 16'd0);
      if (i == 0) t0 = $time;
      if (i == 1) check("R2 sck period", 16'($time - t0), 16'd32);
      @(negedge sck_o);
      if (i < n - 1) sdi = pat[n - 2 - i];
      if (i == wr_at) bus_write(2'd0, wr_val);
      if (i == rd_at) begin
        bus_read(2'd0, d);
        check("R7 first word read mid-run", d, rd_exp);
        check("R7 select held between frames", {15'd0, ss_n_o}, 16'd0);
      end
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic s_run(input int n, input logic [15:0] pat, output logic [15:0] cap);
    cap = '0;
    @(negedge clk); ss_n_i = 1'b0; sdi = pat[n-1];
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sck_i = 1'b1; cap = {cap[14:0], sdo};
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
      repeat (8) @(negedge clk);
      if (i < n - 1) sdi = pat[n - 2 - i];
    end
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    bus_read(2'd2, d); check("R1 status", d, 16'h0000);
    bus_read(2'd1, d); check("R1 control", d, 16'h0000);
    check("R1 pins", {11'd0, ss_n_o, sck_o, sck_oe, irq, 1'b0}, 16'h0010);
  endtask

  task automatic t_master8;
    logic [15:0] d, cap;
    bus_write(2'd0, 16'h00A5);
    bus_read(2'd2, d); check("R6 txfull after write", d & 16'h2, 16'h2);
    bus_read(2'd0, d); check("R11 read returns receive side", d, 16'h0000);
    sdi = 1'b0; // pattern 3C, MSB first
    bus_write(2'd1, 16'h040B);
    m_run(8, 16'h003C, -1, 16'h0, -1, 16'h0, cap);
    check("R2 sent bits", cap & 16'hFF, 16'h00A5);
    bus_read(2'd2, d); check("R6 status after frame", d, 16'h0009);
    check("R5 irq raised", {15'd0, irq}, 16'd1);
    bus_read(2'd0, d); check("R2 received word", d, 16'h003C);
    bus_read(2'd2, d); check("R6 rxfull cleared by read", d & 16'h1, 16'h0);
    bus_write(2'd2, 16'h0008);
    check("R5 flag cleared", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_master16;
    logic [15:0] d, cap;
    bus_write(2'd1, 16'h0406);
    bus_write(2'd0, 16'hC3A1);
    sdi = 1'b0; // 5E96 MSB
    bus_write(2'd1, 16'h0407);
    m_run(16, 16'h5E96, -1, 16'h0, -1, 16'h0, cap);
    check("R3 sent 16 bits", cap, 16'hC3A1);
    bus_read(2'd0, d); check("R3 received 16 bits", d, 16'h5E96);
    bus_read(2'd2, d); check("R5 flag set with irq disabled", d & 16'h8, 16'h8);
    check("R5 irq gated off", {15'd0, irq}, 16'd0);
    bus_write(2'd2, 16'h0008);
  endtask

  task automatic t_back2back;
    logic [15:0] d, cap;
    bus_write(2'd1, 16'h0402);
    bus_write(2'd0, 16'h0081);
    sdi = 1'b0; // 1234 MSB
    bus_write(2'd1, 16'h0403);
    m_run(16, 16'h1234, 1, 16'h007E, 7, 16'h0012, cap);
    check("R7 two words sent back to back", cap, 16'h817E);
    bus_read(2'd0, d); check("R7 second word", d, 16'h0034);
    bus_read(2'd2, d); check("R7 idle after queue drained", d & 16'h12, 16'h0);
  endtask

  task automatic t_slave;
    logic [15:0] d, cap;
    bus_write(2'd1, 16'h0000);
    bus_write(2'd2, 16'h0008);
    bus_write(2'd0, 16'h0096);
    bus_write(2'd1, 16'h0009);
    repeat (4) @(negedge clk);
    check("R10 sdo idle while deselected", {15'd0, sdo}, 16'd0);
    check("R10 no clock drive in slave", {15'd0, sck_oe}, 16'd0);
    s_run(8, 16'h005A, cap);
    check("R10 slave sent word", cap & 16'hFF, 16'h0096);
    bus_read(2'd2, d); check("R6 slave rxfull and tx taken", d & 16'h3, 16'h1);
    s_run(8, 16'h00C7, cap);
    bus_read(2'd2, d); check("R8 overflow flagged", d & 16'h4, 16'h4);
    bus_write(2'd2, 16'h0008);
    s_run(8, 16'h00FF, cap);
    check("R9 no completion during overflow", {15'd0, irq}, 16'd0);
    bus_read(2'd0, d); check("R8 old word kept", d, 16'h005A);
    bus_read(2'd2, d); check("R9 read clears overflow", d & 16'h5, 16'h0);
    s_run(8, 16'h003E, cap);
    bus_read(2'd0, d); check("R9 shifting resumes", d, 16'h003E);
    s_run(3, 16'h0005, cap);
    s_run(8, 16'h00A9, cap);
    bus_read(2'd0, d); check("R10 aborted frame discarded", d, 16'h00A9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_master8;
    t_master16;
    t_back2back;
    t_slave;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule